// File: doc/BRIEF.md
# Multi-channel APB countdown timer

This block is a bus-mapped peripheral holding eight independent 32-bit down-counters. Every channel decrements once for each cycle in which the shared `tick_en` input is high. Each channel has its own interrupt line. Software writes a count base and a control word. A set of single-bit actions in the control word latches that base into the channel's held countdown value and starts, restarts or stops the count.

A channel that reaches its end either stops on its own or reloads and keeps running. It records the event in a shared sticky status word, and it signals the event either as a one-cycle pulse or as a level that stays high until software acknowledges it. The block sits on a zero-wait-state APB port. Each channel also has a compare register that software can read and write, but it has no effect on the count.

Top module: `mtimer_apb`

## Requirements
- R1: After reset every control, count-base, compare and status register reads 0, every current-count read returns 0 and all `irq` lines are low.
- R2: Address map (32-bit aligned; any address with `paddr[1:0]` not 00 is unmapped). Status is at 0x000. Channel n (1..8) has control at n*0x10+0x0, count base at +0x4, compare at +0x8 and current count at +0xC (read-only). Everything else, including 0x090, reads 0 and ignores writes. The control register keeps bits 0,1,2,4,5,6 (read mask 0x77). Compare holds any value and does not affect counting.
- R3: A control write with bit 2 (update) set copies the count base into the channel's held countdown value. If bit 1 (start) is set in the same write, counting begins from that new value.
- R4: A control write with start set and update clear restarts counting from the held value. A count-base write alone leaves a running count unchanged.
- R5: While start is set, each cycle with `tick_en` high lowers the count by one. The current-count register returns the remaining count while start is set and 0 while it is clear.
- R6: A running channel expires when it is ticked at a count of 1, or in the first cycle it holds a count of 0. A stopped channel never expires.
- R7: On expiry with bit 4 (auto-reload) clear, the channel clears its own start bit and stops.
- R8: On expiry with auto-reload set, the count reloads from the held value and the channel keeps running.
- R9: On expiry with bit 5 (interrupt enable) set, status bit (n-1) becomes 1 in the next cycle. With bit 5 clear, neither status nor `irq` changes.
- R10: With bit 6 set, an enabled expiry drives `irq[n-1]` high for exactly one cycle. With bit 6 clear, the line goes high and stays high until it is cleared through status.
- R11: A status write clears each bit written as 1, together with the matching level interrupt, and leaves bits written as 0 unchanged. An expiry in the same cycle as a clear of the same bit wins, so the bit stays set.
- R12: A control write to a channel in the cycle in which it would expire takes precedence, and that expiry is dropped (no status, no pulse, no reload).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Shared count tick, one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, no wait states |
| irq | output | 8 | Per-channel interrupt, bit n-1 for channel n |

## Verification
Two things can fall in the same cycle. An expiry can set a status bit in the same cycle that a software write clears it, and a control write can land on a channel in the cycle it expires. Both are forced by directed cases that run a channel with a zero count and auto-reload, so that it expires every cycle; status clears and control writes then always land on an expiry. In that setup the status bit must survive the clear while a bit not being set is dropped, and an edge-mode line must be low right after the stopping control write. Random traffic with random ticks then repeats these collisions against a cycle-based model in the bench that compares every `irq` line each cycle and every read value.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // Control word layout; positions are decoded by software.
  localparam int CTRL_W   = 7;
  localparam int CB_EXT   = 0;
  localparam int CB_RUN   = 1;
  localparam int CB_LOAD  = 2;
  localparam int CB_AUTO  = 4;
  localparam int CB_IE    = 5;
  localparam int CB_EDGE  = 6;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 7'h77;

  // Register within a channel slot, from paddr[3:2].
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_BASE = 2'd1,
    FLD_CMP  = 2'd2,
    FLD_CNT  = 2'd3
  } fld_e;

  function automatic logic [CTRL_W-1:0] ctrl_filter(input logic [CTRL_W-1:0] w);
    return w & CTRL_KEEP;
  endfunction

endpackage

// File: rtl/mtimer_regs.sv
module mtimer_regs
  import mtimer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CW  = 32
) (
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [AW-1:0]               paddr,
  input  logic [NCH-1:0][CTRL_W-1:0]  ctrl_all,
  input  logic [NCH-1:0][CW-1:0]      base_all,
  input  logic [NCH-1:0][CW-1:0]      cmp_all,
  input  logic [NCH-1:0][CW-1:0]      obs_all,
  input  logic [NCH-1:0]              stat_all,
  output logic [NCH-1:0]              wr_ctrl,
  output logic [NCH-1:0]              wr_base,
  output logic [NCH-1:0]              wr_cmp,
  output logic                        wr_stat,
  output logic [DW-1:0]               prdata
);

  localparam int SLOT_W = AW - 4;

  logic [SLOT_W-1:0] slot;
  fld_e              fld;
  logic              aligned;
  logic              wr_acc;
  logic              stat_hit;

  assign slot     = paddr[AW-1:4];
  assign fld      = fld_e'(paddr[3:2]);
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_acc   = psel & penable & pwrite & aligned;
  assign stat_hit = (paddr[AW-1:2] == '0);
  assign wr_stat  = wr_acc & stat_hit;

  // Channel n lives in slot n; slot 0 holds only the status word.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wr_ctrl[i] = wr_acc && (slot == SLOT_W'(i + 1)) && (fld == FLD_CTRL);
      wr_base[i] = wr_acc && (slot == SLOT_W'(i + 1)) && (fld == FLD_BASE);
      wr_cmp[i]  = wr_acc && (slot == SLOT_W'(i + 1)) && (fld == FLD_CMP);
    end
  end

  always_comb begin
    prdata = '0;
    if (aligned) begin
      if (stat_hit) begin
        prdata = DW'(stat_all);
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (slot == SLOT_W'(i + 1)) begin
            unique case (fld)
              FLD_CTRL: prdata = DW'(ctrl_all[i]);
              FLD_BASE: prdata = DW'(base_all[i]);
              FLD_CMP:  prdata = DW'(cmp_all[i]);
              FLD_CNT:  prdata = DW'(obs_all[i]);
              default:  prdata = '0;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan
  import mtimer_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic              wr_base,
  input  logic              wr_cmp,
  input  logic [CW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CW-1:0]     base_q,
  output logic [CW-1:0]     cmp_q,
  output logic [CW-1:0]     obs,
  output logic              expire,
  output logic              run,
  output logic              ie,
  output logic              edge_mode,
  output logic              auto_ld
);

  logic [CW-1:0] held_q;
  logic [CW-1:0] cur_q;
  logic [CW-1:0] held_nx;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  function automatic logic at_end(input logic [CW-1:0] v, input logic t);
    return (v == '0) || (t && (v == CW'(1)));
  endfunction

  assign run       = ctrl_q[CB_RUN];
  assign ie        = ctrl_q[CB_IE];
  assign edge_mode = ctrl_q[CB_EDGE];
  assign auto_ld   = ctrl_q[CB_AUTO];

  // A control write to this channel pre-empts its expiry.
  assign expire  = run & ~wr_ctrl & at_end(cur_q, tick);
  assign held_nx = wdata[CB_LOAD] ? base_q : held_q;
  assign obs     = run ? cur_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      held_q <= '0;
      cur_q  <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_filter(wdata[CTRL_W-1:0]);
      held_q <= held_nx;
      if (wdata[CB_RUN]) cur_q <= held_nx;
    end else if (expire) begin
      if (auto_ld) cur_q <= held_q;
      else         ctrl_q[CB_RUN] <= 1'b0;
    end else if (run && tick) begin
      cur_q <= step_down(cur_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_cmp)  cmp_q  <= wdata;
    end
  end

endmodule

// File: rtl/mtimer_irq.sv
module mtimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic edge_mode,
  input  logic clr,
  output logic stat_q,
  output logic irq
);

  logic pulse_q;
  logic lvl_q;

  // Setting takes priority over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      pulse_q <= fire & edge_mode;
      if (fire)     stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
      if (fire && !edge_mode) lvl_q <= 1'b1;
      else if (clr)           lvl_q <= 1'b0;
    end
  end

  assign irq = pulse_q | lvl_q;

endmodule

// File: rtl/mtimer_apb.sv
module mtimer_apb
  import mtimer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic           pready,
  output logic [NCH-1:0] irq
);

  localparam int CW = DW;

  logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NCH-1:0][CW-1:0]     base_all;
  logic [NCH-1:0][CW-1:0]     cmp_all;
  logic [NCH-1:0][CW-1:0]     obs_all;
  logic [NCH-1:0]             wr_ctrl, wr_base, wr_cmp;
  logic                       wr_stat;

  // Named events brought out for the checker.
  logic [NCH-1:0] ev_expire;
  logic [NCH-1:0] cfg_ie, cfg_edge, cfg_auto;
  logic [NCH-1:0] st_run, st_stat;

  assign pready = 1'b1;

  mtimer_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_regs (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .ctrl_all (ctrl_all),
    .base_all (base_all),
    .cmp_all  (cmp_all),
    .obs_all  (obs_all),
    .stat_all (st_stat),
    .wr_ctrl  (wr_ctrl),
    .wr_base  (wr_base),
    .wr_cmp   (wr_cmp),
    .wr_stat  (wr_stat),
    .prdata   (prdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mtimer_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .wr_ctrl   (wr_ctrl[g]),
      .wr_base   (wr_base[g]),
      .wr_cmp    (wr_cmp[g]),
      .wdata     (pwdata),
      .ctrl_q    (ctrl_all[g]),
      .base_q    (base_all[g]),
      .cmp_q     (cmp_all[g]),
      .obs       (obs_all[g]),
      .expire    (ev_expire[g]),
      .run       (st_run[g]),
      .ie        (cfg_ie[g]),
      .edge_mode (cfg_edge[g]),
      .auto_ld   (cfg_auto[g])
    );

    mtimer_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (ev_expire[g] & cfg_ie[g]),
      .edge_mode (cfg_edge[g]),
      .clr       (wr_stat & pwdata[g]),
      .stat_q    (st_stat[g]),
      .irq       (irq[g])
    );
  end

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           psel,
  input logic           penable,
  input logic           pwrite,
  input logic [AW-1:0]  paddr,
  input logic [DW-1:0]  pwdata,
  input logic [NCH-1:0] ev_expire,
  input logic [NCH-1:0] cfg_ie,
  input logic [NCH-1:0] cfg_edge,
  input logic [NCH-1:0] cfg_auto,
  input logic [NCH-1:0] st_run,
  input logic [NCH-1:0] st_stat,
  input logic [NCH-1:0] irq
);

  logic sw_clear;
  assign sw_clear = psel && penable && pwrite && (paddr == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r6_stopped_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      !st_run[g] |-> !ev_expire[g]);

    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ev_expire[g] && !cfg_auto[g] |=> !st_run[g]);

    a_r8_reload_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      ev_expire[g] && cfg_auto[g] |=> st_run[g]);

    a_r9_status_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      ev_expire[g] && cfg_ie[g] |=> st_stat[g]);

    a_r10_irq_follows_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      ev_expire[g] && cfg_ie[g] |=> irq[g]);

    a_r11_clear_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear && pwdata[g] && !(ev_expire[g] && cfg_ie[g]) |=> !st_stat[g]);

    a_r11_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_stat[g]) |-> $past(sw_clear && pwdata[g]));

    a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && !cfg_edge[g] && !(sw_clear && pwdata[g]) && !$past(cfg_edge[g]) |=> irq[g]);
  end

endmodule

bind mtimer_apb mtimer_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .ev_expire (ev_expire),
  .cfg_ie    (cfg_ie),
  .cfg_edge  (cfg_edge),
  .cfg_auto  (cfg_auto),
  .st_run    (st_run),
  .st_stat   (st_stat),
  .irq       (irq)
);

// File: tb/mtimer_apb_tb.sv
`timescale 1ns/1ps
module mtimer_apb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  irq;

  int vectors = 0;
  int errors  = 0;
  bit mon_on  = 1'b0;

  always #2.5 clk = ~clk;

  mtimer_apb u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq)
  );

  // ---------------- bench model (from the requirements) ----------------
  logic [6:0]  m_ctrl [8];
  logic [31:0] m_base [8], m_cmp [8], m_held [8], m_cur [8];
  logic [7:0]  m_stat, m_pulse, m_lvl;
  bit          b_wr, b_swclr, b_wc, b_run, b_ex, b_fire, b_edge, b_clr;
  logic [7:0]  b_slot;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_ctrl[i] = '0; m_base[i] = '0; m_cmp[i] = '0; m_held[i] = '0; m_cur[i] = '0;
      end
      m_stat = '0; m_pulse = '0; m_lvl = '0;
    end else begin
      b_wr    = psel && penable && pwrite && (paddr[1:0] == 2'b00);
      b_slot  = paddr[11:4];
      b_swclr = b_wr && (paddr[11:2] == 10'd0);
      for (int i = 0; i < 8; i++) begin
        b_wc   = b_wr && (b_slot == 8'(i + 1)) && (paddr[3:2] == 2'd0);
        b_run  = m_ctrl[i][1];
        b_ex   = b_run && !b_wc && ((m_cur[i] == 0) || (tick_en && m_cur[i] == 1));
        b_fire = b_ex && m_ctrl[i][5];
        b_edge = m_ctrl[i][6];
        b_clr  = b_swclr && pwdata[i];
        m_pulse[i] = b_fire && b_edge;
        if (b_fire && !b_edge) m_lvl[i] = 1'b1; else if (b_clr) m_lvl[i] = 1'b0;
        if (b_fire) m_stat[i] = 1'b1; else if (b_clr) m_stat[i] = 1'b0;
        if (b_wc) begin
          m_ctrl[i] = pwdata[6:0] & 7'h77;
          if (pwdata[2]) m_held[i] = m_base[i];
          if (pwdata[1]) m_cur[i] = m_held[i];
        end else if (b_ex) begin
          if (m_ctrl[i][4]) m_cur[i] = m_held[i];
          else m_ctrl[i][1] = 1'b0;
        end else if (b_run && tick_en) begin
          m_cur[i] = m_cur[i] - 1;
        end
        if (b_wr && b_slot == 8'(i + 1) && paddr[3:2] == 2'd1) m_base[i] = pwdata;
        if (b_wr && b_slot == 8'(i + 1) && paddr[3:2] == 2'd2) m_cmp[i]  = pwdata;
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [7:0] s;
    s = a[11:4];
    if (a[1:0] != 2'b00) return '0;
    if (a[11:2] == 10'd0) return {24'd0, m_stat};
    if (s >= 1 && s <= 8) begin
      case (a[3:2])
        2'd0: return {25'd0, m_ctrl[s-1]};
        2'd1: return m_base[s-1];
        2'd2: return m_cmp[s-1];
        default: return m_ctrl[s-1][1] ? m_cur[s-1] : 32'd0;
      endcase
    end
    return '0;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) check("R10 irq vs model", {24'd0, irq}, {24'd0, m_pulse | m_lvl});
  end

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d, output logic [31:0] m);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    m = model_read(a);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d, m;
    apb_read(a, d, m);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seed;
    int cnt;
    logic [31:0] d, m;
    seed = 32'h1f2e3d4c;
    void'($urandom(seed));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 reset state
    read_check("R1 status", 12'h000, 32'd0);
    read_check("R1 ctrl1", 12'h010, 32'd0);
    read_check("R1 base3", 12'h034, 32'd0);
    read_check("R1 cmp5", 12'h058, 32'd0);
    read_check("R1 cnt8", 12'h08C, 32'd0);
    check("R1 irq", {24'd0, irq}, 32'd0);

    // R2 map, masking, unmapped
    apb_write(12'h020, 32'hFFFF_FF89);
    read_check("R2 ctrl mask", 12'h020, 32'h0000_0001);
    apb_write(12'h028, 32'hDEAD_BEEF);
    read_check("R2 cmp rw", 12'h028, 32'hDEAD_BEEF);
    apb_write(12'h090, 32'h1234_5678);
    apb_write(12'h100, 32'hFFFF_FFFF);
    apb_write(12'h016, 32'h0000_0006);
    read_check("R2 rev reads 0", 12'h090, 32'd0);
    read_check("R2 unmapped 0", 12'h100, 32'd0);
    read_check("R2 misaligned write ignored", 12'h010, 32'd0);
    read_check("R2 status untouched", 12'h000, 32'd0);

    // R3 / R5 update+start then count
    apb_write(12'h014, 32'd5);
    apb_write(12'h010, 32'h06);
    read_check("R3 load base", 12'h01C, 32'd5);
    ticks(2);
    read_check("R5 decrement", 12'h01C, 32'd3);

    // R4 base write alone, then restart from held
    apb_write(12'h014, 32'd100);
    read_check("R4 base no effect", 12'h01C, 32'd3);
    apb_write(12'h010, 32'h02);
    read_check("R4 restart held", 12'h01C, 32'd5);

    // R6 R7 R9 R10 one-shot level
    apb_write(12'h014, 32'd3);
    apb_write(12'h010, 32'h26);
    ticks(3);
    read_check("R7 start cleared", 12'h010, 32'h24);
    read_check("R5 stopped reads 0", 12'h01C, 32'd0);
    read_check("R9 status bit0", 12'h000, 32'h01);
    check("R10 level high", {31'd0, irq[0]}, 32'd1);

    // R11 write-one-to-clear
    apb_write(12'h000, 32'h0);
    read_check("R11 zero keeps", 12'h000, 32'h01);
    apb_write(12'h000, 32'h1);
    read_check("R11 one clears", 12'h000, 32'h00);
    check("R11 level dropped", {31'd0, irq[0]}, 32'd0);

    // R10 edge pulse on channel 4
    apb_write(12'h044, 32'd2);
    apb_write(12'h040, 32'h66);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (irq[3]) cnt++;
      tick_en = (k < 5);
    end
    tick_en = 1'b0;
    check("R10 one pulse", cnt, 32'd1);
    read_check("R9 status bit3", 12'h000, 32'h08);
    apb_write(12'h000, 32'h08);

    // R8 auto-reload on channel 6
    apb_write(12'h064, 32'd4);
    apb_write(12'h060, 32'h76);
    cnt = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (irq[5]) cnt++;
      tick_en = (k < 12);
    end
    tick_en = 1'b0;
    check("R8 three expiries", cnt, 32'd3);
    read_check("R8 still running", 12'h060, 32'h76);
    read_check("R8 reloaded", 12'h06C, 32'd4);
    apb_write(12'h060, 32'h0);
    apb_write(12'h000, 32'h20);

    // R6 zero load expires without ticks
    apb_write(12'h074, 32'd0);
    apb_write(12'h070, 32'h26);
    read_check("R6 zero expiry", 12'h070, 32'h24);
    read_check("R6 status bit6", 12'h000, 32'h40);

    // R11 clear collides with expiry
    apb_write(12'h054, 32'd0);
    apb_write(12'h050, 32'h36);
    apb_write(12'h000, 32'h50);
    read_check("R11 set wins", 12'h000, 32'h10);
    check("R11 irq4 kept", {31'd0, irq[4]}, 32'd1);
    check("R11 irq6 dropped", {31'd0, irq[6]}, 32'd0);
    apb_write(12'h050, 32'h0);
    apb_write(12'h000, 32'h10);
    read_check("R11 cleared", 12'h000, 32'h00);

    // R12 control write beats expiry (edge channel expiring every cycle)
    apb_write(12'h034, 32'd0);
    apb_write(12'h030, 32'h76);
    apb_write(12'h030, 32'h00);
    #1;
    check("R12 no pulse", {31'd0, irq[2]}, 32'd0);
    apb_write(12'h000, 32'h04);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int unsigned ch, op;
      logic [11:0] a;
      ch = $urandom_range(1, 8);
      op = $urandom_range(0, 9);
      tick_en = ($urandom_range(0, 3) != 0);
      case (op)
        0, 1: apb_write(12'(ch * 16), $urandom & 32'h7F);
        2:    apb_write(12'(ch * 16 + 4), 32'($urandom_range(0, 6)));
        3:    apb_write(12'(ch * 16 + 8), $urandom);
        4:    apb_write(12'h000, $urandom);
        5:    apb_write(12'($urandom), $urandom);
        default: begin
          a = (op == 9) ? 12'($urandom) : 12'(ch * 16 + 4 * $urandom_range(0, 3));
          if (op == 8) a = 12'h000;
          apb_read(a, d, m);
          check("R5 random read", d, m);
        end
      endcase
    end
    tick_en = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule